// File: doc/BRIEF.md
# Register-Mapped Signed Divider

This block is a small division peripheral on a 32-bit register bus. Software first loads a divisor. It then writes a dividend to one of two start registers. Writing the 32-bit dividend register runs a signed 32-bit by 32-bit division. Writing the low dividend word runs a signed 64-bit by 32-bit division, and the high word is taken from the register just below it. The results appear in a group of readable registers. The quotient and the remainder are each written to more than one location, so software can read either copy.

The arithmetic runs in an iterative shift-and-subtract engine. It spends one cycle loading, one cycle per dividend bit, and one cycle writing the results back. A busy output covers the whole operation. While busy is high the bus cannot change anything, and reads return the results of the last completed operation. Two special cases are handled at write-back. A zero divisor clears the result registers. A 64-bit quotient that is too wide for 32 bits is clamped to the nearest signed 32-bit limit.

Top module: `mmioDivider`

## Requirements
- R1: After reset every register reads zero and `busy` is low.
- R2: While idle, writes to word 0 (divisor), word 4 (high dividend / remainder), word 6 (remainder copy) and word 7 (quotient copy) store the written value, which reads back unchanged.
- R3: A write to word 1 starts a signed 32÷32 divide of the written value by word 0. The quotient is truncated toward zero and is written to words 1, 5 and 7. The remainder takes the sign of the dividend and is written to words 4 and 6.
- R4: A write to word 5 starts a signed 64÷32 divide of {word 4, written value} by word 0. The remainder goes to words 4 and 6, the quotient goes to words 5 and 7, and word 1 is left unchanged.
- R5: In 64÷32 mode, a quotient outside the signed 32-bit range is written as 0x7FFFFFFF when it is positive and as 0x80000000 when it is negative. The remainder is still exact.
- R6: In 32÷32 mode the quotient is not clamped. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: A divide with word 0 equal to zero sets words 4, 5, 6 and 7 to zero and leaves word 1 unchanged.
- R8: `busy` goes high in the cycle after a start write. It stays high for exactly 65 cycles, and the new results are readable in the first cycle in which `busy` is low.
- R9: While `busy` is high, every write is ignored, including further start writes, and reads return the results of the previous operation.
- R10: Words 2 and 3 always read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the word at `addr` |
| addr | input | 3 | Word index for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| busy | output | 1 | High while a division is in progress |

## Verification
The embedded assertions check on every cycle that:
- a start raises `busy`;
- `busy` drops right after write-back;
- all registers stay frozen while a division runs;
- the quotient and remainder copies agree after write-back;
- a zero divisor clears the results;
- the remainder carries the sign of the dividend.

Only the bench scenarios can show that the quotient and remainder values are correct. This covers truncation, the clamp at both limits, the unclamped wrap in 32-bit mode, and operands chosen at random. The bench also shows that the 65-cycle busy window holds and that start writes issued while busy are really discarded.

// File: rtl/divPkg.sv
package divPkg;
  localparam logic [2:0] IDX_DVS    = 3'd0;
  localparam logic [2:0] IDX_DVD32  = 3'd1;
  localparam logic [2:0] IDX_HIGH   = 3'd4;
  localparam logic [2:0] IDX_QUO    = 3'd5;
  localparam logic [2:0] IDX_REMMIR = 3'd6;
  localparam logic [2:0] IDX_QUOMIR = 3'd7;

  typedef struct packed {
    logic loadOp;
    logic mode64;
    logic step;
    logic commit;
    logic wrDvs;
    logic wrHigh;
    logic wrRemMir;
    logic wrQuoMir;
  } divCtlT;
endpackage

// File: rtl/divCtrl.sv
module divCtrl import divPkg::*; #(
  parameter int ITERS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] addr,
  output logic       busy,
  output divCtlT     ctl
);
  localparam int CNT_W = $clog2(ITERS);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} stateT;
  stateT state;
  logic [CNT_W-1:0] cnt;
  logic idle;

  assign idle = (state == S_IDLE);
  assign busy = !idle;

  always_comb begin
    ctl = '0;
    if (idle && wrEn) begin
      case (addr)
        IDX_DVS:    ctl.wrDvs = 1'b1;
        IDX_HIGH:   ctl.wrHigh = 1'b1;
        IDX_REMMIR: ctl.wrRemMir = 1'b1;
        IDX_QUOMIR: ctl.wrQuoMir = 1'b1;
        IDX_DVD32:  ctl.loadOp = 1'b1;
        IDX_QUO: begin
          ctl.loadOp = 1'b1;
          ctl.mode64 = 1'b1;
        end
        default: ;
      endcase
    end
    ctl.step   = (state == S_RUN);
    ctl.commit = (state == S_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (ctl.loadOp) begin
          state <= S_RUN;
          cnt   <= '0;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(ITERS - 1)) state <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && (addr == IDX_DVD32 || addr == IDX_QUO)) |=> busy); // R8
  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> !busy); // R8
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(ctl.commit)); // R8
endmodule

// File: rtl/divDatapath.sv
module divDatapath import divPkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        addr,
  input  divCtlT            ctl,
  input  logic              busy,
  output logic [DATA_W-1:0] rdData
);
  localparam int DW2 = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] dvsReg, quoA, remA, quoB, remB, quoC;
  logic [DW2-1:0]    quoSh;
  logic [DATA_W-1:0] remSh, dvsAbs;
  logic              negQ, negR, zeroDvs, modeL;

  logic [DW2-1:0]    dvdFull, dvdAbsC;
  logic [DATA_W-1:0] dvsAbsC;
  logic [DATA_W:0]   trial, diff;
  logic              geFlag;
  logic [DATA_W-1:0] remNext;
  logic [DW2-1:0]    qSigned;
  logic [DATA_W-1:0] rSigned, q32;
  logic              fits;

  always_comb begin
    dvdFull = ctl.mode64 ? {remA, wrData} : {{DATA_W{wrData[DATA_W-1]}}, wrData};
    dvdAbsC = dvdFull[DW2-1] ? (DW2'(0) - dvdFull) : dvdFull;
    dvsAbsC = dvsReg[DATA_W-1] ? (DATA_W'(0) - dvsReg) : dvsReg;

    trial   = {remSh, quoSh[DW2-1]};
    diff    = trial - {1'b0, dvsAbs};
    geFlag  = (trial >= {1'b0, dvsAbs});
    remNext = geFlag ? diff[DATA_W-1:0] : trial[DATA_W-1:0];

    qSigned = negQ ? (DW2'(0) - quoSh) : quoSh;
    rSigned = negR ? (DATA_W'(0) - remSh) : remSh;
    fits    = (&qSigned[DW2-1:DATA_W-1]) || !(|qSigned[DW2-1:DATA_W-1]);
    if (modeL && !fits) q32 = negQ ? MAX_NEG : MAX_POS;
    else                q32 = qSigned[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoSh   <= '0;
      remSh   <= '0;
      dvsAbs  <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      zeroDvs <= 1'b0;
      modeL   <= 1'b0;
    end else if (ctl.loadOp) begin
      quoSh   <= dvdAbsC;
      remSh   <= '0;
      dvsAbs  <= dvsAbsC;
      negR    <= dvdFull[DW2-1];
      negQ    <= dvdFull[DW2-1] ^ dvsReg[DATA_W-1];
      zeroDvs <= (dvsReg == '0);
      modeL   <= ctl.mode64;
    end else if (ctl.step) begin
      quoSh <= {quoSh[DW2-2:0], geFlag};
      remSh <= remNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvsReg <= '0;
      quoA   <= '0;
      remA   <= '0;
      quoB   <= '0;
      remB   <= '0;
      quoC   <= '0;
    end else if (ctl.commit) begin
      if (zeroDvs) begin
        remA <= '0;
        remB <= '0;
        quoB <= '0;
        quoC <= '0;
      end else begin
        remA <= rSigned;
        remB <= rSigned;
        quoB <= q32;
        quoC <= q32;
        if (!modeL) quoA <= q32;
      end
    end else begin
      if (ctl.wrDvs)    dvsReg <= wrData;
      if (ctl.wrHigh)   remA   <= wrData;
      if (ctl.wrRemMir) remB   <= wrData;
      if (ctl.wrQuoMir) quoC   <= wrData;
    end
  end

  always_comb begin
    case (addr)
      IDX_DVS:    rdData = dvsReg;
      IDX_DVD32:  rdData = quoA;
      IDX_HIGH:   rdData = remA;
      IDX_QUO:    rdData = quoB;
      IDX_REMMIR: rdData = remB;
      IDX_QUOMIR: rdData = quoC;
      default:    rdData = '0;
    endcase
  end

  AST_MIRROR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (quoB == quoC && remA == remB)); // R3
  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.commit) |=> ($stable(dvsReg) && $stable(quoA) && $stable(remA)
      && $stable(quoB) && $stable(remB) && $stable(quoC))); // R9
  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && zeroDvs) |=> (quoB == '0 && remA == '0 && remB == '0 && quoC == '0)); // R7
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && !zeroDvs) |=> (remA == '0 || remA[DATA_W-1] == negR)); // R3
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.loadOp); // R9
endmodule

// File: rtl/mmioDivider.sv
module mmioDivider import divPkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);
  localparam int ITERS = 2 * DATA_W;

  divCtlT ctl;

  divCtrl #(.ITERS(ITERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .busy(busy), .ctl(ctl)
  );

  divDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .addr(addr), .ctl(ctl),
    .busy(busy), .rdData(rdData)
  );
endmodule

// File: tb/mmioDivider_tb.sv
module mmioDivider_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic        busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] eDvs, e104, e110, e114, e118, e11C;

  mmioDivider u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [31:0] val);
    addr = idx;
    #1;
    val = rdData;
  endtask

  task automatic doWrite(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkAll(string req);
    logic [31:0] v;
    readReg(3'd0, v); check(req, v, eDvs);
    readReg(3'd1, v); check(req, v, e104);
    readReg(3'd4, v); check(req, v, e110);
    readReg(3'd5, v); check(req, v, e114);
    readReg(3'd6, v); check(req, v, e118);
    readReg(3'd7, v); check(req, v, e11C);
  endtask

  function automatic string model(bit m64, logic [31:0] lo);
    logic signed [64:0] n, d, q, r;
    logic [31:0] q32;
    string tag;
    tag = m64 ? "R4" : "R3";
    if (eDvs == 32'd0) begin
      e110 = 0; e114 = 0; e118 = 0; e11C = 0;
      return "R7";
    end
    n = m64 ? {e110[31], e110, lo} : {{33{lo[31]}}, lo};
    d = {{33{eDvs[31]}}, eDvs};
    q = n / d;
    r = n % d;
    q32 = q[31:0];
    if (m64 && q > 65'sd2147483647) begin q32 = 32'h7FFFFFFF; tag = "R5"; end
    if (m64 && q < -65'sd2147483648) begin q32 = 32'h80000000; tag = "R5"; end
    if (!m64 && q > 65'sd2147483647) tag = "R6";
    e110 = r[31:0]; e118 = r[31:0];
    e114 = q32; e11C = q32;
    if (!m64) e104 = q32;
    return tag;
  endfunction

  task automatic runOp(bit m64, logic [31:0] dvs, logic [31:0] hi, logic [31:0] lo);
    int cnt;
    string tag;
    doWrite(3'd0, dvs); eDvs = dvs;
    if (m64) begin doWrite(3'd4, hi); e110 = hi; end
    doWrite(m64 ? 3'd5 : 3'd1, lo);
    cnt = 0;
    while (busy && cnt < 200) begin
      cnt++;
      @(negedge clk);
    end
    check("R8 busy length", 32'(cnt), 32'd65);
    tag = model(m64, lo);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    eDvs = 0; e104 = 0; e110 = 0; e114 = 0; e118 = 0; e11C = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    checkAll("R1");
    readReg(3'd2, v); check("R1", v, 0);

    // R2 plain register writes
    doWrite(3'd0, 32'h1234_5678); eDvs = 32'h1234_5678;
    doWrite(3'd4, 32'hCAFE_0001); e110 = 32'hCAFE_0001;
    doWrite(3'd6, 32'h0BAD_F00D); e118 = 32'h0BAD_F00D;
    doWrite(3'd7, 32'h5555_AAAA); e11C = 32'h5555_AAAA;
    checkAll("R2");
    check("R2 no start", {31'd0, busy}, 32'd0);

    // R10 unused words
    doWrite(3'd2, 32'hFFFF_FFFF);
    doWrite(3'd3, 32'hFFFF_FFFF);
    readReg(3'd2, v); check("R10", v, 0);
    readReg(3'd3, v); check("R10", v, 0);
    checkAll("R10");

    // R3 truncation and remainder sign
    runOp(1'b0, 32'hFFFF_FFFE, 0, 32'd7);
    check("R3 q", e114, 32'hFFFF_FFFD);
    runOp(1'b0, 32'd2, 0, 32'hFFFF_FFF9);
    check("R3 r", e110, 32'hFFFF_FFFF);
    // R6 wrap in 32-bit mode
    runOp(1'b0, 32'hFFFF_FFFF, 0, 32'h8000_0000);
    check("R6 q", e104, 32'h8000_0000);
    // R4 64-bit, word 1 unchanged
    runOp(1'b1, 32'd1000, 32'd3, 32'h0000_0010);
    // R5 saturation both signs
    runOp(1'b1, 32'd1, 32'd1, 32'd0);
    check("R5 pos", e114, 32'h7FFF_FFFF);
    runOp(1'b1, 32'hFFFF_FFFF, 32'd1, 32'd0);
    check("R5 neg", e114, 32'h8000_0000);
    runOp(1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd0);
    runOp(1'b1, 32'd3, 32'hFFFF_FFFF, 32'hFFFF_FFF0);
    // R7 zero divisor in both modes
    runOp(1'b0, 32'd0, 0, 32'd99);
    runOp(1'b1, 32'd0, 32'd5, 32'd99);

    // R9 writes while busy ignored
    runOp(1'b0, 32'd9, 0, 32'd50);
    doWrite(3'd0, 32'd5); eDvs = 32'd5;
    doWrite(3'd1, 32'd100);
    readReg(3'd5, v); check("R9 old result", v, e114);
    doWrite(3'd0, 32'd0);
    doWrite(3'd5, 32'd77);
    doWrite(3'd4, 32'd123);
    doWrite(3'd7, 32'd1);
    while (busy) @(negedge clk);
    void'(model(1'b0, 32'd100));
    checkAll("R9");
    repeat (3) @(negedge clk);
    check("R9 no restart", {31'd0, busy}, 32'd0);

    // random mix
    for (int i = 0; i < 120; i++) begin
      bit m64;
      logic [31:0] dvs, hi, lo;
      m64 = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 9))
        0:       dvs = 32'd0;
        1, 2, 3: dvs = 32'($signed($urandom_range(0, 255)) - 128);
        default: dvs = $urandom;
      endcase
      lo = $urandom;
      if ($urandom_range(0, 1) == 1) hi = {32{lo[31]}};
      else hi = $urandom;
      runOp(m64, dvs, hi, lo);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule